// File: doc/BRIEF.md
# Packet memory allocation unit

This block hands out a small pool of equal-sized packet buffer pages to a transmit side and a receive side that share them. It tracks which pages are taken in a bitmap. Page numbers travel through three queues: a transmit queue of pages waiting to be sent, a receive queue of pages holding arrived frames, and a completion queue of pages the transmitter has finished with. Software drives it through a byte-wide register port. A write to the command register carries a 3-bit operation code. Other registers hold the packet number, the allocation result, the queue heads, the interrupt status, the acknowledge and the mask.

The receive datapath asks for a page with a single-cycle request and is told the same cycle whether one was granted and which. The transmit datapath drains the transmit queue through a valid/ready handshake, one page per accepted beat. Each sent page is either freed at once or parked on the completion queue, depending on an auto-release input. A level interrupt is raised whenever a status bit that is also enabled in the mask is set.

A command sees queue contents as they stood at the start of its cycle. An allocation made by a command sees the pages taken and freed in that same cycle, so two allocations never return one page.

Top module: `pma_alloc_unit`

## Requirements
- R1: After reset the status register (address 5) reads 0x04, the mask (address 6) reads 0x00, the allocation result (address 2) reads 0x00, both queue heads (addresses 3 and 4) read 0x80, the used-page count (address 7) reads 0, and `irq` is low.
- R2: A command write to address 0 with bits 7:5 = 1 (byte 0x20) clears status bit 3 (ALLOC) and tries to allocate. On success it stores the lowest-numbered free page at address 2 and sets ALLOC. With every page taken it stores 0x80 and leaves ALLOC clear.
- R3: While the allocation result holds 0x80, any page release (command 4, command 5, or an auto-released transmit) retries the allocation, and on success stores the page and sets ALLOC.
- R4: `rx_req` is granted in the same cycle when a page is free and the receive queue holds fewer than QDEPTH entries. The granted page is the lowest free one; it is marked taken, pushed onto the receive queue and sets status bit 0 (RCV). Otherwise `rx_grant` stays low and nothing changes.
- R5: Command 3 (0x60) pops the receive queue. Command 4 (0x80) pops it and frees the popped page. After a pop, RCV is set if entries remain and cleared otherwise. A pop of an empty queue changes nothing.
- R6: Command 6 (0xC0) appends the packet number (address 1) to the transmit queue, and is dropped when the queue is full. `tx_valid` is high while `tx_enable` is high and the queue is non-empty. `tx_page` shows the oldest entry, and each `tx_valid && tx_ready` beat removes one entry.
- R7: With `auto_release` low, a sent page is appended to the completion queue (head at address 3). With `auto_release` high, the page is freed instead. Status bit 1 (TX) is set while the completion queue is non-empty.
- R8: A write to address 5 clears the status bits in (value AND 0xD6). If value bit 1 is set, the completion queue head is popped. RCV and ALLOC are not touched by it.
- R9: `irq` is high exactly when (status AND mask) is non-zero. The mask is written and read at address 6.
- R10: Command 2 (0x40) frees all pages, empties all three queues and sets the allocation result to 0x00. Command 7 (0xE0) empties only the transmit and completion queues.
- R11: Address 7 reads the number of pages currently taken.
- R12: Status bit 2 (TX_EMPTY) is set whenever the transmit queue is empty. Once set, it stays set after the queue fills until an acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| rx_req | input | 1 | Receive side asks for a page |
| rx_grant | output | 1 | Request granted this cycle |
| rx_page | output | PG_W | Page given to the receive side |
| tx_enable | input | 1 | Transmitter allowed to drain the queue |
| auto_release | input | 1 | Free sent pages instead of queueing completion |
| tx_valid | output | 1 | A page is offered for sending |
| tx_ready | input | 1 | Transmitter takes the offered page |
| tx_page | output | PG_W | Oldest page of the transmit queue |
| irq | output | 1 | Level interrupt |

## Verification
Allocation is exercised by filling the pool through commands and then through receive requests. This separates the lowest-free choice from a plain counter, because pages are freed out of order before they are reused. The pending-retry case is driven by a release into a full pool. Releasing twice tells a one-shot retry apart from one that repeats. Transmit drain is run with three pages queued out of numeric order, and again with auto-release on and with more enqueues than the queue holds. These runs separate FIFO order, the choice between completion and freeing, and the drop on a full queue. Acknowledge patterns that touch only TX_EMPTY or only TX show that the sticky bits and the completion pop are independent.

// File: rtl/pma_pkg.sv
package pma_pkg;
  // empty marker for allocation result and queue heads
  localparam logic [7:0] PMA_NONE = 8'h80;

  // register addresses
  localparam logic [2:0] A_CMD    = 3'd0;
  localparam logic [2:0] A_PNUM   = 3'd1;
  localparam logic [2:0] A_ARES   = 3'd2;
  localparam logic [2:0] A_DONE   = 3'd3;
  localparam logic [2:0] A_RXHEAD = 3'd4;
  localparam logic [2:0] A_ISTAT  = 3'd5;
  localparam logic [2:0] A_IMASK  = 3'd6;
  localparam logic [2:0] A_USED   = 3'd7;

  // command codes, taken from write data bits 7:5
  localparam logic [2:0] C_NOP     = 3'd0;
  localparam logic [2:0] C_TXALLOC = 3'd1;
  localparam logic [2:0] C_UNITRST = 3'd2;
  localparam logic [2:0] C_RXPOP   = 3'd3;
  localparam logic [2:0] C_RXFREE  = 3'd4;
  localparam logic [2:0] C_RELEASE = 3'd5;
  localparam logic [2:0] C_TXPUSH  = 3'd6;
  localparam logic [2:0] C_TXCLR   = 3'd7;

  // status bit positions
  localparam int IB_RCV   = 0;
  localparam int IB_TX    = 1;
  localparam int IB_TXE   = 2;
  localparam int IB_ALLOC = 3;

  // bits an acknowledge write may clear
  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
endpackage

// File: rtl/pma_fifo.sv
module pma_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // full queue drops the push; empty queue ignores the pop
  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/pma_pool.sv
module pma_pool #(
  parameter int NUM_PAGES = 4,
  localparam int PG_W     = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic [NUM_PAGES-1:0] rel_mask,
  input  logic                 rx_take,
  input  logic                 cmd_take,
  output logic [NUM_PAGES-1:0] bitmap,
  output logic                 rx_ok,
  output logic [PG_W-1:0]      rx_idx,
  output logic                 cmd_ok,
  output logic [PG_W-1:0]      cmd_idx
);
  logic [NUM_PAGES-1:0] after_rx, free_now, free_cmd;

  function automatic logic [PG_W-1:0] lowest_set(input logic [NUM_PAGES-1:0] v);
    logic [PG_W-1:0] r;
    r = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (v[i]) r = PG_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NUM_PAGES-1:0] page_bit(input logic [PG_W-1:0] i);
    return NUM_PAGES'(1) << i;
  endfunction

  // receive sees the pool as of the start of the cycle
  assign free_now = ~bitmap;
  assign rx_ok    = |free_now;
  assign rx_idx   = lowest_set(free_now);

  // commands see this cycle's releases and the receive grant
  assign after_rx = (bitmap & ~rel_mask) | (rx_take ? page_bit(rx_idx) : '0);
  assign free_cmd = ~after_rx;
  assign cmd_ok   = |free_cmd;
  assign cmd_idx  = lowest_set(free_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) bitmap <= '0;
    else bitmap <= after_rx | ((cmd_take && cmd_ok) ? page_bit(cmd_idx) : '0);
  end
endmodule

// File: rtl/pma_irq.sv
module pma_irq
  import pma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txq_empty,
  input  logic       done_busy,
  input  logic       rx_set,
  input  logic       rx_pop_upd,
  input  logic       rx_left,
  input  logic       alloc_clr,
  input  logic       alloc_set,
  input  logic       ack_wr,
  input  logic [7:0] ack_val,
  input  logic       mask_wr,
  input  logic [7:0] mask_val,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);
  logic       rcv_q, alloc_q, txe_q, tx_q;
  logic [7:0] ack_clr;

  assign ack_clr = ack_wr ? (ack_val & ACK_CLEARABLE) : 8'h00;

  always_comb begin
    status            = 8'h00;
    status[IB_RCV]    = rcv_q;
    status[IB_TX]     = tx_q | done_busy;
    status[IB_TXE]    = txe_q | txq_empty;
    status[IB_ALLOC]  = alloc_q;
  end

  assign irq = |(status & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcv_q   <= 1'b0;
      alloc_q <= 1'b0;
      txe_q   <= 1'b0;
      tx_q    <= 1'b0;
      mask    <= 8'h00;
    end else begin
      // sticky copies of the live conditions, cleared only by acknowledge
      txe_q <= status[IB_TXE] & ~ack_clr[IB_TXE];
      tx_q  <= status[IB_TX]  & ~ack_clr[IB_TX];
      if (rx_pop_upd)  rcv_q <= rx_left;
      else if (rx_set) rcv_q <= 1'b1;
      if (alloc_clr)      alloc_q <= alloc_set;
      else if (alloc_set) alloc_q <= 1'b1;
      if (mask_wr) mask <= mask_val;
    end
  end
endmodule

// File: rtl/pma_alloc_unit.sv
module pma_alloc_unit
  import pma_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = NUM_PAGES,
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int CW       = $clog2(QDEPTH + 1),
  localparam int UW       = $clog2(NUM_PAGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            rx_req,
  output logic            rx_grant,
  output logic [PG_W-1:0] rx_page,
  input  logic            tx_enable,
  input  logic            auto_release,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [PG_W-1:0] tx_page,
  output logic            irq
);
  // register state
  logic [7:0] pnum_q, alloc_res;
  logic [7:0] int_status, int_mask;

  // decoded events, named for the checker
  logic       cmd_w, ack_w, mask_w;
  logic [2:0] cmd_code;
  logic       c_txalloc, c_unitrst, c_rxpop, c_rxfree, c_release, c_txpush, c_txclr;
  logic       ev_drain, ev_release, ev_retry, ev_take, ev_alloc_hit;
  logic       pn_ok;
  logic [PG_W-1:0] pn_idx;

  // queue and pool wires
  logic [PG_W-1:0] txq_head, rxq_head, doneq_head;
  logic [CW-1:0]   txq_cnt, rxq_cnt, doneq_cnt;
  logic            txq_empty, rxq_empty, doneq_empty, rxq_full;
  logic [NUM_PAGES-1:0] bitmap, rel_mask;
  logic            rx_ok, cmd_ok;
  logic [PG_W-1:0] cmd_idx;
  logic            rx_pop_upd, rx_left;

  function automatic logic [UW-1:0] pages_taken(input logic [NUM_PAGES-1:0] v);
    logic [UW-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_PAGES; i++) n = n + UW'(v[i]);
    return n;
  endfunction

  function automatic logic [7:0] head_byte(input logic empty, input logic [PG_W-1:0] h);
    return empty ? PMA_NONE : 8'(h);
  endfunction

  function automatic logic [NUM_PAGES-1:0] page_bit(input logic [PG_W-1:0] i);
    return NUM_PAGES'(1) << i;
  endfunction

  // decode
  assign cmd_w     = reg_wr && (reg_addr == A_CMD);
  assign ack_w     = reg_wr && (reg_addr == A_ISTAT);
  assign mask_w    = reg_wr && (reg_addr == A_IMASK);
  assign cmd_code  = reg_wdata[7:5];
  assign c_txalloc = cmd_w && (cmd_code == C_TXALLOC);
  assign c_unitrst = cmd_w && (cmd_code == C_UNITRST);
  assign c_rxpop   = cmd_w && (cmd_code == C_RXPOP);
  assign c_rxfree  = cmd_w && (cmd_code == C_RXFREE);
  assign c_release = cmd_w && (cmd_code == C_RELEASE);
  assign c_txpush  = cmd_w && (cmd_code == C_TXPUSH);
  assign c_txclr   = cmd_w && (cmd_code == C_TXCLR);

  assign pn_ok  = pnum_q < 8'(NUM_PAGES);
  assign pn_idx = pnum_q[PG_W-1:0];

  assign txq_empty   = (txq_cnt == '0);
  assign rxq_empty   = (rxq_cnt == '0);
  assign doneq_empty = (doneq_cnt == '0);
  assign rxq_full    = (rxq_cnt == CW'(QDEPTH));

  // receive side
  assign rx_grant = rx_req && rx_ok && !rxq_full;

  // transmit side
  assign tx_valid = tx_enable && !txq_empty;
  assign tx_page  = txq_head;
  assign ev_drain = tx_valid && tx_ready;

  // page releases of this cycle
  assign rel_mask = ((ev_drain && auto_release)    ? page_bit(txq_head) : '0)
                  | ((c_rxfree && !rxq_empty)      ? page_bit(rxq_head) : '0)
                  | ((c_release && pn_ok)          ? page_bit(pn_idx)   : '0);
  assign ev_release   = (ev_drain && auto_release) || (c_rxfree && !rxq_empty)
                     || (c_release && pn_ok);
  assign ev_retry     = ev_release && (alloc_res == PMA_NONE) && !c_txalloc;
  assign ev_take      = (c_txalloc || ev_retry) && !c_unitrst;
  assign ev_alloc_hit = ev_take && cmd_ok;

  // receive status update after a real pop
  assign rx_pop_upd = (c_rxpop || c_rxfree) && !rxq_empty;
  assign rx_left    = (rxq_cnt > CW'(1)) || rx_grant;

  pma_pool #(.NUM_PAGES(NUM_PAGES)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (c_unitrst),
    .rel_mask (rel_mask),
    .rx_take  (rx_grant),
    .cmd_take (ev_take),
    .bitmap   (bitmap),
    .rx_ok    (rx_ok),
    .rx_idx   (rx_page),
    .cmd_ok   (cmd_ok),
    .cmd_idx  (cmd_idx)
  );

  pma_fifo #(.DEPTH(QDEPTH), .W(PG_W)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (c_unitrst || c_txclr),
    .push      (c_txpush && pn_ok),
    .push_data (pn_idx),
    .pop       (ev_drain),
    .head      (txq_head),
    .count     (txq_cnt)
  );

  pma_fifo #(.DEPTH(QDEPTH), .W(PG_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (c_unitrst),
    .push      (rx_grant),
    .push_data (rx_page),
    .pop       (c_rxpop || c_rxfree),
    .head      (rxq_head),
    .count     (rxq_cnt)
  );

  pma_fifo #(.DEPTH(QDEPTH), .W(PG_W)) u_doneq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (c_unitrst || c_txclr),
    .push      (ev_drain && !auto_release),
    .push_data (txq_head),
    .pop       (ack_w && reg_wdata[IB_TX]),
    .head      (doneq_head),
    .count     (doneq_cnt)
  );

  pma_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .txq_empty  (txq_empty),
    .done_busy  (!doneq_empty),
    .rx_set     (rx_grant),
    .rx_pop_upd (rx_pop_upd),
    .rx_left    (rx_left),
    .alloc_clr  (c_txalloc),
    .alloc_set  (ev_alloc_hit),
    .ack_wr     (ack_w),
    .ack_val    (reg_wdata),
    .mask_wr    (mask_w),
    .mask_val   (reg_wdata),
    .status     (int_status),
    .mask       (int_mask),
    .irq        (irq)
  );

  // packet number and allocation result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnum_q    <= 8'h00;
      alloc_res <= 8'h00;
    end else begin
      if (reg_wr && (reg_addr == A_PNUM)) pnum_q <= reg_wdata;
      if (c_unitrst)    alloc_res <= 8'h00;
      else if (ev_take) alloc_res <= cmd_ok ? 8'(cmd_idx) : PMA_NONE;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_PNUM:   reg_rdata = pnum_q;
      A_ARES:   reg_rdata = alloc_res;
      A_DONE:   reg_rdata = head_byte(doneq_empty, doneq_head);
      A_RXHEAD: reg_rdata = head_byte(rxq_empty, rxq_head);
      A_ISTAT:  reg_rdata = int_status;
      A_IMASK:  reg_rdata = int_mask;
      A_USED:   reg_rdata = 8'(pages_taken(bitmap));
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/pma_alloc_unit_chk.sv
module pma_alloc_unit_chk #(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = NUM_PAGES,
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int CW       = $clog2(QDEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [2:0]           reg_addr,
  input logic [7:0]           reg_wdata,
  input logic [7:0]           reg_rdata,
  input logic                 rx_grant,
  input logic [PG_W-1:0]      rx_page,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 auto_release,
  input logic [NUM_PAGES-1:0] bitmap,
  input logic [7:0]           alloc_res,
  input logic [7:0]           int_status,
  input logic [7:0]           int_mask,
  input logic [CW-1:0]        txq_cnt,
  input logic [CW-1:0]        rxq_cnt,
  input logic [CW-1:0]        doneq_cnt
);
  p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> !bitmap[rx_page]);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> (rxq_cnt < CW'(QDEPTH)));

  p_rx_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4 && rxq_cnt == '0) |-> (reg_rdata == 8'h80));

  p_full_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[7:5] == 3'd1 && (&bitmap)
     && !(tx_valid && tx_ready && auto_release))
    |=> (alloc_res == 8'h80 && !int_status[3]));

  p_txq_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (txq_cnt != '0));

  p_tx_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (doneq_cnt != '0) |-> int_status[1]);

  p_ack_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5 && reg_wdata[1] && doneq_cnt != '0
     && !(tx_valid && tx_ready && !auto_release))
    |=> (doneq_cnt == $past(doneq_cnt) - CW'(1)));

  p_mask_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd6) |=> (int_mask == $past(reg_wdata)));

  p_unit_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[7:5] == 3'd2)
    |=> (bitmap == '0 && txq_cnt == '0 && rxq_cnt == '0 && doneq_cnt == '0
         && alloc_res == 8'h00));

  p_txe_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_cnt == '0) |-> int_status[2]);
endmodule

bind pma_alloc_unit pma_alloc_unit_chk #(.NUM_PAGES(NUM_PAGES), .QDEPTH(QDEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .rx_grant     (rx_grant),
  .rx_page      (rx_page),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .auto_release (auto_release),
  .bitmap       (bitmap),
  .alloc_res    (alloc_res),
  .int_status   (int_status),
  .int_mask     (int_mask),
  .txq_cnt      (txq_cnt),
  .rxq_cnt      (rxq_cnt),
  .doneq_cnt    (doneq_cnt)
);

// File: tb/pma_alloc_unit_tb.sv
module pma_alloc_unit_tb;
  localparam int PG_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [2:0]      reg_addr = 3'd0;
  logic [7:0]      reg_wdata = 8'h00;
  logic [7:0]      reg_rdata;
  logic            rx_req = 1'b0;
  logic            rx_grant;
  logic [PG_W-1:0] rx_page;
  logic            tx_enable = 1'b0;
  logic            auto_release = 1'b0;
  logic            tx_valid;
  logic            tx_ready = 1'b0;
  logic [PG_W-1:0] tx_page;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pma_alloc_unit u_dut (
    .clk (clk), .rst_n (rst_n),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .rx_req (rx_req), .rx_grant (rx_grant), .rx_page (rx_page),
    .tx_enable (tx_enable), .auto_release (auto_release),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_page (tx_page),
    .irq (irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] c);
    wr(3'd0, {c, 5'b0});
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic bit_chk(input string tag, input int pos, input int exp);
    @(negedge clk);
    reg_addr = 3'd5;
    #1 chk(tag, reg_rdata[pos], exp);
  endtask

  task automatic pin_chk(input string tag, input logic v, input int exp);
    @(negedge clk);
    #1 chk(tag, v, exp);
  endtask

  task automatic rx_try(input int exp_g, input int exp_p);
    @(negedge clk);
    rx_req = 1'b1;
    #1 chk("R4 rx_grant", rx_grant, exp_g);
    if (exp_g != 0) chk("R4 rx_page", rx_page, exp_p);
    @(posedge clk);
    #1 rx_req = 1'b0;
  endtask

  task automatic hs(input int exp_p);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 chk("R6 tx_valid", tx_valid, 1);
    chk("R6 tx_page order", tx_page, exp_p);
    @(posedge clk);
    #1 tx_ready = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    rd_chk("R1 status", 3'd5, 8'h04);
    rd_chk("R1 mask", 3'd6, 8'h00);
    rd_chk("R1 alloc result", 3'd2, 8'h00);
    rd_chk("R1 done head", 3'd3, 8'h80);
    rd_chk("R1 rx head", 3'd4, 8'h80);
    rd_chk("R1 used", 3'd7, 0);
    pin_chk("R1 irq", irq, 0);
  endtask

  task automatic t_txalloc;
    for (int i = 0; i < 4; i++) begin
      cmd(3'd1);
      rd_chk("R2 lowest page", 3'd2, i);
      bit_chk("R2 ALLOC set", 3, 1);
    end
    cmd(3'd1);
    rd_chk("R2 pool full result", 3'd2, 8'h80);
    bit_chk("R2 ALLOC clear on fail", 3, 0);
    rd_chk("R11 used full", 3'd7, 4);
    wr(3'd1, 8'd2);
    cmd(3'd5);
    rd_chk("R3 retry page", 3'd2, 2);
    bit_chk("R3 ALLOC after retry", 3, 1);
    rd_chk("R11 used after retry", 3'd7, 4);
    wr(3'd1, 8'd1);
    cmd(3'd5);
    rd_chk("R3 no second retry", 3'd2, 2);
    rd_chk("R11 used after release", 3'd7, 3);
    cmd(3'd2);
    rd_chk("R10 unit reset used", 3'd7, 0);
    rd_chk("R10 unit reset result", 3'd2, 8'h00);
  endtask

  task automatic t_rx;
    for (int i = 0; i < 4; i++) rx_try(1, i);
    bit_chk("R4 RCV set", 0, 1);
    rx_try(0, 0);
    rd_chk("R4 refused used", 3'd7, 4);
    rd_chk("R4 rx head", 3'd4, 0);
    cmd(3'd3);
    rd_chk("R5 pop head", 3'd4, 1);
    bit_chk("R5 RCV remains", 0, 1);
    rd_chk("R5 plain pop keeps page", 3'd7, 4);
    cmd(3'd4);
    rd_chk("R5 pop+free head", 3'd4, 2);
    rd_chk("R5 pop+free used", 3'd7, 3);
    rx_try(1, 1);
    cmd(3'd4);
    rd_chk("R5 head after free", 3'd4, 3);
    cmd(3'd4);
    rd_chk("R5 head order", 3'd4, 1);
    cmd(3'd4);
    rd_chk("R5 rx empty head", 3'd4, 8'h80);
    bit_chk("R5 RCV cleared", 0, 0);
    rd_chk("R5 used after drain", 3'd7, 1);
    cmd(3'd3);
    rd_chk("R5 empty pop head", 3'd4, 8'h80);
    bit_chk("R5 empty pop RCV", 0, 0);
    rd_chk("R5 empty pop used", 3'd7, 1);
    cmd(3'd2);
  endtask

  task automatic t_tx;
    int n;
    for (int i = 0; i < 3; i++) cmd(3'd1);
    wr(3'd1, 8'd2); cmd(3'd6);
    wr(3'd1, 8'd0); cmd(3'd6);
    wr(3'd1, 8'd1); cmd(3'd6);
    bit_chk("R12 TX_EMPTY sticky", 2, 1);
    wr(3'd5, 8'h04);
    bit_chk("R12 TX_EMPTY acked", 2, 0);
    bit_chk("R8 ack keeps ALLOC", 3, 1);
    pin_chk("R6 tx_valid gated", tx_valid, 0);
    tx_enable = 1'b1;
    hs(2);
    rd_chk("R7 done head", 3'd3, 2);
    bit_chk("R7 TX set", 1, 1);
    pin_chk("R9 irq masked off", irq, 0);
    wr(3'd6, 8'h02);
    pin_chk("R9 irq on TX", irq, 1);
    rd_chk("R9 mask readback", 3'd6, 8'h02);
    hs(0);
    hs(1);
    pin_chk("R6 queue drained", tx_valid, 0);
    bit_chk("R12 TX_EMPTY again", 2, 1);
    wr(3'd5, 8'h02);
    rd_chk("R8 done pop 1", 3'd3, 0);
    wr(3'd5, 8'h02);
    rd_chk("R8 done pop 2", 3'd3, 1);
    wr(3'd5, 8'h02);
    rd_chk("R8 done empty", 3'd3, 8'h80);
    bit_chk("R8 TX cleared", 1, 0);
    pin_chk("R9 irq low", irq, 0);
    wr(3'd6, 8'h04);
    pin_chk("R9 irq on TX_EMPTY", irq, 1);
    rd_chk("R7 used no auto", 3'd7, 3);
    auto_release = 1'b1;
    wr(3'd1, 8'd1); cmd(3'd6);
    hs(1);
    auto_release = 1'b0;
    rd_chk("R7 auto freed", 3'd7, 2);
    rd_chk("R7 auto not queued", 3'd3, 8'h80);
    tx_enable = 1'b0;
    wr(3'd1, 8'd0);
    for (int i = 0; i < 5; i++) cmd(3'd6);
    tx_enable = 1'b1;
    n = 0;
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tx_valid) n++;
    end
    tx_ready = 1'b0;
    tx_enable = 1'b0;
    chk("R6 full queue drops", n + 1, 4);
    rd_chk("R7 done head full", 3'd3, 0);
    cmd(3'd7);
    rd_chk("R10 clear done head", 3'd3, 8'h80);
    rd_chk("R10 clear keeps pool", 3'd7, 2);
  endtask

  initial begin
    t_reset();
    t_txalloc();
    t_rx();
    t_tx();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule